// File: doc/BRIEF.md
# Fault Protection and Auto-Restart Manager

This block sits beside the gate-drive logic of a primary-side-regulated LED converter and decides, once per switching cycle, whether switching may continue. It receives already-sampled comparator flags (output-sense level against the fold-back and short thresholds, output and supply over-voltage, whether the current-sense signal reached the short-check level, and a die over-temperature pair), together with a switching-cycle strobe and the phase reported by the startup sequencer. It drives the peak-current limit selection, a gate-disable signal, a code naming the cause of the last trip, and a one-cycle restart request back to the startup sequencer.

Each fault is qualified in its own way. A shorted output must persist over several consecutive switching cycles and is ignored until startup has fully finished. A shorted sense resistor is judged only over the first switching cycles of the current-mode startup phase. Over-voltage and over-temperature act at once. After any trip, switching stops for a fixed restart delay counted in clock ticks; pin-based faults then ask the sequencer for a fresh startup, while an over-temperature trip keeps re-arming the delay until the die has cooled past its release point.

Top module: `fault_restart_mgr`

## Requirements
- R1: During and directly after reset, `cl_low`, `gate_off` and `restart_req` are 0 and `fault_code` is 0 (no fault).
- R2: The limit select `cl_low` changes only on a cycle with `cyc_strobe` high: it becomes 1 one clock later if `vs_below_lo` is high, else becomes 0 if `vs_above_hi` is high, else keeps its value (hysteresis between the two thresholds).
- R3: With `seq_phase` = 3 (run), a short trip happens on the third consecutive strobe carrying `vs_short`; the fault code is then 2.
- R4: The short-output count restarts on any strobe without `vs_short`; cycles without a strobe leave it unchanged.
- R5: `vs_short` causes no trip while `seq_phase` is 0, 1 or 2 (startup phases one to three).
- R6: An output over-voltage trip happens at once on `vdd_ovp` in any cycle, or on `vs_ovp` in a strobe cycle; `vs_ovp` without a strobe is ignored. The fault code is 1.
- R7: While `seq_phase` = 2, only the first two strobes are examined; if `cs_reached` is low on both, a sense-resistor trip happens on the second, code 3. A reach on either of them, or a miss on later strobes, causes no trip.
- R8: `ot_trip` high in any cycle causes an immediate over-temperature trip, code 4.
- R9: Simultaneous trips are coded by priority: over-temperature (4) over output over-voltage (1) over short output (2) over sense-resistor short (3).
- R10: `gate_off` rises on the clock edge that registers the trip and stays high for exactly RESTART_TICKS cycles for a pin-based fault.
- R11: At the end of the delay, `gate_off` falls and `restart_req` is high for exactly one cycle, in the same cycle.
- R12: For code 4, if `ot_release` is low at the end of a delay period, the delay re-arms with no restart request; restart follows the first period end at which `ot_release` is high.
- R13: While `gate_off` is high no new trip is taken and `fault_code` holds; after restart, the code holds until the first cycle that sees `seq_phase` = 3 with gating enabled, and reads 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_strobe | input | 1 | One pulse per switching cycle; sampled flags valid with it |
| seq_phase | input | 2 | Sequencer phase: 0,1,2 startup phases one to three, 3 run |
| vs_below_lo | input | 1 | Sampled output sense under lower fold-back threshold |
| vs_above_hi | input | 1 | Sampled output sense over upper fold-back threshold |
| vs_short | input | 1 | Sampled output sense under short-output threshold |
| vs_ovp | input | 1 | Sampled output sense over the over-voltage threshold |
| vdd_ovp | input | 1 | Supply over its over-voltage level |
| cs_reached | input | 1 | Current sense reached the short-check level this cycle |
| ot_trip | input | 1 | Die temperature above trip point |
| ot_release | input | 1 | Die temperature below release point |
| cl_low | output | 1 | 1 selects the low peak-current limit, 0 the high one |
| gate_off | output | 1 | Gate switching disabled |
| fault_code | output | 3 | Cause of last trip: 0 none, 1 over-voltage, 2 short, 3 sense short, 4 over-temperature |
| restart_req | output | 1 | One-cycle request for a new startup sequence |

## Verification
The bench interrupts a run of short-output strobes with one clean strobe and with strobe-free cycles, so a debounce that fails to clear, or that counts clock cycles instead of strobes, trips too early or never. It drives short and sense-resistor conditions in the wrong sequencer phases and past the first two startup strobes, where a loosely gated qualifier would shut the gate spuriously. It holds the die hot across a full delay period to catch a design that restarts without the release, checks that a late over-voltage during the hold neither re-triggers nor overwrites the stored cause, and fires several faults in one cycle to expose a wrong priority order.

// File: rtl/frm_pkg.sv
// Shared types for the fault protection and auto-restart manager.
// Assumes a 2-bit sequencer phase code and a 3-bit fault code.
package frm_pkg;

    typedef enum logic [1:0] {
        PH_STEP1 = 2'd0,
        PH_STEP2 = 2'd1,
        PH_STEP3 = 2'd2,
        PH_RUN   = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_OVOLT = 3'd1,
        FC_SHORT = 3'd2,
        FC_SENSE = 3'd3,
        FC_HOT   = 3'd4
    } fcode_e;

    typedef struct packed {
        logic hot;
        logic ovolt;
        logic short_out;
        logic sense;
    } hits_t;

endpackage

// File: rtl/frm_climit.sv
// Peak-current limit selection with hysteresis.
// Assumes the two threshold flags are sampled once per switching cycle
// and are valid only together with the strobe.
module frm_climit (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_strobe,
    input  logic vs_below_lo,
    input  logic vs_above_hi,
    output logic cl_low
);

    // Fold to the low limit below the lower threshold, recover above the upper one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_low <= 1'b0;
        end else if (cyc_strobe) begin
            if (vs_below_lo) begin
                cl_low <= 1'b1;
            end else if (vs_above_hi) begin
                cl_low <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/frm_qualify.sv
// Fault qualification: turns raw sampled flags into trip hits.
// Short output needs SHORT_CYCLES consecutive strobes in the run phase;
// sense-resistor short is judged over the first SENSE_CYCLES strobes of
// startup phase three; over-voltage and over-temperature act at once.
// Assumes `halted` is high for the whole restart delay; all state clears then.
module frm_qualify
    import frm_pkg::*;
#(
    parameter int SHORT_CYCLES = 3,
    parameter int SENSE_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halted,
    input  logic   cyc_strobe,
    input  phase_e phase,
    input  logic   vs_short,
    input  logic   vs_ovp,
    input  logic   vdd_ovp,
    input  logic   cs_reached,
    input  logic   ot_trip,
    output hits_t  hits
);

    localparam int SW = $clog2(SHORT_CYCLES + 1);
    localparam int NW = $clog2(SENSE_CYCLES + 1);
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_CYCLES - 1);
    localparam logic [NW-1:0] SENSE_LAST = NW'(SENSE_CYCLES - 1);
    localparam logic [NW-1:0] SENSE_END  = NW'(SENSE_CYCLES);

    logic          in_run;
    logic          in_step3;
    logic [SW-1:0] short_cnt;
    logic [NW-1:0] sense_cnt;
    logic          sense_allmiss;

    assign in_run   = (phase == PH_RUN);
    assign in_step3 = (phase == PH_STEP3);

    // Count consecutive short-output strobes; any clean strobe restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_cnt <= '0;
        end else if (halted || !in_run) begin
            short_cnt <= '0;
        end else if (cyc_strobe) begin
            short_cnt <= vs_short ? short_cnt + SW'(1) : '0;
        end
    end

    // Track the opening strobes of phase three and whether all missed the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_cnt     <= '0;
            sense_allmiss <= 1'b1;
        end else if (halted || !in_step3) begin
            sense_cnt     <= '0;
            sense_allmiss <= 1'b1;
        end else if (cyc_strobe && (sense_cnt != SENSE_END)) begin
            sense_cnt     <= sense_cnt + NW'(1);
            sense_allmiss <= sense_allmiss & ~cs_reached;
        end
    end

    // Combine the qualified conditions into trip hits, blocked while halted.
    always_comb begin
        hits           = '0;
        hits.hot       = ot_trip;
        hits.ovolt     = vdd_ovp | (cyc_strobe & vs_ovp);
        hits.short_out = cyc_strobe & in_run & vs_short & (short_cnt == SHORT_LAST);
        hits.sense     = cyc_strobe & in_step3 & (sense_cnt == SENSE_LAST)
                         & sense_allmiss & ~cs_reached;
        if (halted) begin
            hits = '0;
        end
    end

endmodule

// File: rtl/frm_restart.sv
// Trip latch, fault code and auto-restart delay.
// Takes the highest-priority hit, disables the gate from the next edge,
// counts RESTART_TICKS cycles, then either requests a startup or, for an
// over-temperature trip without release, counts another period.
// Assumes hits are already blocked while the delay runs.
module frm_restart
    import frm_pkg::*;
#(
    parameter int RESTART_TICKS = 100_000_000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  hits_t  hits,
    input  phase_e phase,
    input  logic   ot_release,
    output logic   gate_off,
    output logic   restart_req,
    output fcode_e fault_code
);

    localparam int CW = (RESTART_TICKS > 1) ? $clog2(RESTART_TICKS) : 1;
    localparam logic [CW-1:0] LOAD = CW'(RESTART_TICKS - 1);

    typedef enum logic {ST_ARMED = 1'b0, ST_HOLD = 1'b1} st_e;

    st_e           state;
    logic [CW-1:0] delay_cnt;
    fcode_e        trip_code;
    logic          any_trip;

    assign any_trip = |hits;
    assign gate_off = (state == ST_HOLD);

    // Priority encode simultaneous hits; later assignments win.
    always_comb begin
        trip_code = FC_NONE;
        if (hits.sense)     trip_code = FC_SENSE;
        if (hits.short_out) trip_code = FC_SHORT;
        if (hits.ovolt)     trip_code = FC_OVOLT;
        if (hits.hot)       trip_code = FC_HOT;
    end

    // Trip, hold for the delay, then restart or re-arm for over-temperature.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_ARMED;
            delay_cnt   <= '0;
            fault_code  <= FC_NONE;
            restart_req <= 1'b0;
        end else begin
            restart_req <= 1'b0;
            case (state)
                ST_ARMED: begin
                    if (any_trip) begin
                        state      <= ST_HOLD;
                        delay_cnt  <= LOAD;
                        fault_code <= trip_code;
                    end else if (phase == PH_RUN) begin
                        fault_code <= FC_NONE;
                    end
                end
                ST_HOLD: begin
                    if (delay_cnt != '0) begin
                        delay_cnt <= delay_cnt - CW'(1);
                    end else if ((fault_code == FC_HOT) && !ot_release) begin
                        delay_cnt <= LOAD;
                    end else begin
                        state       <= ST_ARMED;
                        restart_req <= 1'b1;
                    end
                end
                default: state <= ST_ARMED;
            endcase
        end
    end

endmodule

// File: rtl/fault_restart_mgr.sv
// Top of the fault protection and auto-restart manager.
// Wires the current-limit selector, the fault qualifier and the restart
// controller. Assumes all flag inputs are synchronous to clk.
module fault_restart_mgr
    import frm_pkg::*;
#(
    parameter int RESTART_TICKS = 100_000_000,
    parameter int SHORT_CYCLES  = 3,
    parameter int SENSE_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_strobe,
    input  logic [1:0] seq_phase,
    input  logic       vs_below_lo,
    input  logic       vs_above_hi,
    input  logic       vs_short,
    input  logic       vs_ovp,
    input  logic       vdd_ovp,
    input  logic       cs_reached,
    input  logic       ot_trip,
    input  logic       ot_release,
    output logic       cl_low,
    output logic       gate_off,
    output logic [2:0] fault_code,
    output logic       restart_req
);

    phase_e phase;
    hits_t  hits;
    fcode_e code;

    assign phase      = phase_e'(seq_phase);
    assign fault_code = code;

    frm_climit u_climit (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_strobe  (cyc_strobe),
        .vs_below_lo (vs_below_lo),
        .vs_above_hi (vs_above_hi),
        .cl_low      (cl_low)
    );

    frm_qualify #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .SENSE_CYCLES (SENSE_CYCLES)
    ) u_qualify (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (gate_off),
        .cyc_strobe (cyc_strobe),
        .phase      (phase),
        .vs_short   (vs_short),
        .vs_ovp     (vs_ovp),
        .vdd_ovp    (vdd_ovp),
        .cs_reached (cs_reached),
        .ot_trip    (ot_trip),
        .hits       (hits)
    );

    frm_restart #(
        .RESTART_TICKS (RESTART_TICKS)
    ) u_restart (
        .clk         (clk),
        .rst_n       (rst_n),
        .hits        (hits),
        .phase       (phase),
        .ot_release  (ot_release),
        .gate_off    (gate_off),
        .restart_req (restart_req),
        .fault_code  (code)
    );

endmodule

// File: rtl/frm_checker.sv
// Port-level assertions for fault_restart_mgr, attached by bind.
// Assumes the delay length parameter matches the bound instance.
module frm_checker #(
    parameter int RESTART_TICKS = 100_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_strobe,
    input logic       vs_below_lo,
    input logic       vs_above_hi,
    input logic       ot_release,
    input logic       cl_low,
    input logic       gate_off,
    input logic       restart_req,
    input logic [2:0] fault_code
);

    localparam logic [31:0] TICKS32 = 32'(RESTART_TICKS);

    logic [31:0] run_len;

    // Length of the current run of gate-disabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (gate_off) begin
            run_len <= run_len + 32'd1;
        end else begin
            run_len <= '0;
        end
    end

    a_r2_fold_low: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strobe && vs_below_lo |=> cl_low);

    a_r2_fold_high: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_strobe && !vs_below_lo && vs_above_hi |=> !cl_low);

    a_r2_fold_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strobe |=> $stable(cl_low));

    a_r10_trip_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_off) |-> (fault_code != 3'd0));

    a_r10_window: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (run_len != 32'd0) && ((run_len % TICKS32) == 32'd0));

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    a_r11_req_with_release: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> !gate_off && $past(gate_off));

    a_r12_hot_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req && (fault_code == 3'd4) |-> $past(ot_release));

    a_r13_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off && $past(gate_off) |-> $stable(fault_code));

    a_r9_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code <= 3'd4);

endmodule

bind fault_restart_mgr frm_checker #(
    .RESTART_TICKS (RESTART_TICKS)
) i_frm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_strobe  (cyc_strobe),
    .vs_below_lo (vs_below_lo),
    .vs_above_hi (vs_above_hi),
    .ot_release  (ot_release),
    .cl_low      (cl_low),
    .gate_off    (gate_off),
    .restart_req (restart_req),
    .fault_code  (fault_code)
);

// File: tb/test_fault_restart_mgr.sv
// Scoreboard bench: the driver pushes expected output items with the cycle
// they belong to; a monitor at the falling edge pops and compares them.
module test_fault_restart_mgr;

    localparam int TICKS = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_strobe, vs_below_lo, vs_above_hi, vs_short, vs_ovp;
    logic       vdd_ovp, cs_reached, ot_trip, ot_release;
    logic [1:0] seq_phase;
    logic       cl_low, gate_off, restart_req;
    logic [2:0] fault_code;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    string      q_tag[$];
    int         q_at[$];
    logic [5:0] q_mask[$];
    logic [5:0] q_val[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    fault_restart_mgr #(.RESTART_TICKS(TICKS)) i_fault_restart_mgr (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .seq_phase(seq_phase),
        .vs_below_lo(vs_below_lo), .vs_above_hi(vs_above_hi), .vs_short(vs_short),
        .vs_ovp(vs_ovp), .vdd_ovp(vdd_ovp), .cs_reached(cs_reached),
        .ot_trip(ot_trip), .ot_release(ot_release), .cl_low(cl_low),
        .gate_off(gate_off), .fault_code(fault_code), .restart_req(restart_req)
    );

    // Monitor: compare queued expectations against the outputs.
    always @(negedge clk) begin
        logic [5:0] obs;
        obs = {cl_low, gate_off, restart_req, fault_code};
        while (q_at.size() > 0 && q_at[0] <= cyc) begin
            string      t;
            logic [5:0] m, v;
            t = q_tag.pop_front();
            m = q_mask.pop_front();
            v = q_val.pop_front();
            void'(q_at.pop_front());
            n_cmp++;
            if ((obs & m) !== (v & m)) begin
                n_bad++;
                $display("FAIL %s: actual {cl,gate,req,code}=%b expected %b (mask %b)",
                         t, obs, v, m);
            end
        end
    end

    // Push an expectation for the outputs after the most recent edge; -1 = don't care.
    task automatic chk(input string tag, input int cl, input int g, input int r, input int c);
        logic [5:0] m, v;
        m = '0; v = '0;
        if (cl >= 0) begin m[5] = 1'b1; v[5] = cl[0]; end
        if (g  >= 0) begin m[4] = 1'b1; v[4] = g[0];  end
        if (r  >= 0) begin m[3] = 1'b1; v[3] = r[0];  end
        if (c  >= 0) begin m[2:0] = 3'b111; v[2:0] = c[2:0]; end
        q_tag.push_back(tag); q_at.push_back(cyc);
        q_mask.push_back(m);  q_val.push_back(v);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Present one cycle of pulse inputs, clock it in, then clear them.
    task automatic cyc_in(input bit stb, input bit lo, input bit hi, input bit sh,
                          input bit ov, input bit vdd, input bit cs, input bit hot);
        cyc_strobe = stb; vs_below_lo = lo; vs_above_hi = hi; vs_short = sh;
        vs_ovp = ov; vdd_ovp = vdd; cs_reached = cs; ot_trip = hot;
        step();
        cyc_strobe = 0; vs_below_lo = 0; vs_above_hi = 0; vs_short = 0;
        vs_ovp = 0; vdd_ovp = 0; cs_reached = 0; ot_trip = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc_in(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // After a trip edge: full delay, one-cycle restart, then clear in run phase.
    task automatic hold_restart(input string tag, input int code);
        idle(TICKS - 1);
        chk({tag, " R10 gate held to last delay cycle"}, -1, 1, 0, code);
        idle(1);
        chk({tag, " R11 restart pulse"}, -1, 0, 1, code);
        seq_phase = 2'd3;
        idle(1);
        chk({tag, " R13 code cleared in run"}, -1, 0, 0, 0);
    endtask

    initial begin
        rst_n = 0; seq_phase = 2'd3; ot_release = 0;
        cyc_strobe = 0; vs_below_lo = 0; vs_above_hi = 0; vs_short = 0;
        vs_ovp = 0; vdd_ovp = 0; cs_reached = 0; ot_trip = 0;
        step();
        chk("R1 in reset", 0, 0, 0, 0);
        step();
        rst_n = 1;
        step();
        chk("R1 after reset", 0, 0, 0, 0);

        // R2 fold-back hysteresis
        cyc_in(1, 1, 0, 0, 0, 0, 0, 0); chk("R2 below -> low", 1, 0, -1, -1);
        cyc_in(0, 0, 1, 0, 0, 0, 0, 0); chk("R2 no strobe holds", 1, -1, -1, -1);
        cyc_in(1, 0, 0, 0, 0, 0, 0, 0); chk("R2 mid band holds", 1, -1, -1, -1);
        cyc_in(1, 0, 1, 0, 0, 0, 0, 0); chk("R2 above -> high", 0, -1, -1, -1);
        cyc_in(1, 1, 1, 0, 0, 0, 0, 0); chk("R2 below wins", 1, -1, -1, -1);
        cyc_in(1, 0, 1, 0, 0, 0, 0, 0); chk("R2 back high", 0, -1, -1, -1);

        // R3/R4 short debounce in run phase
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0); chk("R3 two shorts no trip", -1, 0, 0, 0);
        cyc_in(0, 0, 0, 1, 0, 0, 0, 0); chk("R4 strobe-less cycle", -1, 0, 0, 0);
        cyc_in(1, 0, 0, 0, 0, 0, 0, 0); chk("R4 clean strobe resets", -1, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0); chk("R4 count restarted", -1, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0); chk("R3 third short trips", -1, 1, 0, 2);

        // R13 hold: late fault ignored, code held through startup
        idle(5);
        cyc_in(0, 0, 0, 0, 0, 1, 0, 0); chk("R13 no retrip in hold", -1, 1, 0, 2);
        seq_phase = 2'd0;
        idle(TICKS - 8);
        idle(1); chk("R10 gate held", -1, 1, 0, 2);
        idle(1); chk("R11 restart pulse", -1, 0, 1, 2);
        idle(1); chk("R11 pulse one cycle", -1, 0, 0, 2);

        // R5 short ignored before run
        for (int i = 0; i < 4; i++) cyc_in(1, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 short ignored in startup", -1, 0, 0, 2);

        // R7 reach in first strobe prevents trip; later strobes ignored
        seq_phase = 2'd2;
        cyc_in(1, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc_in(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 reach on first strobe", -1, 0, 0, 2);
        seq_phase = 2'd3;
        idle(1); chk("R13 cleared on run", -1, 0, 0, 0);

        // R6 over-voltage
        cyc_in(0, 0, 0, 0, 1, 0, 0, 0); chk("R6 vs_ovp without strobe", -1, 0, 0, 0);
        cyc_in(1, 0, 0, 0, 1, 0, 0, 0); chk("R6 vs_ovp strobe trips", -1, 1, 0, 1);
        hold_restart("R6a", 1);
        cyc_in(0, 0, 0, 0, 0, 1, 0, 0); chk("R6 vdd_ovp trips", -1, 1, 0, 1);
        hold_restart("R6b", 1);

        // R7 sense-resistor short
        seq_phase = 2'd2;
        cyc_in(1, 0, 0, 0, 0, 0, 0, 0); chk("R7 first miss no trip", -1, 0, 0, 0);
        cyc_in(1, 0, 0, 0, 0, 0, 0, 0); chk("R7 second miss trips", -1, 1, 0, 3);
        hold_restart("R7", 3);

        // R8/R12 over-temperature
        cyc_in(0, 0, 0, 0, 0, 0, 0, 1); chk("R8 hot trips", -1, 1, 0, 4);
        idle(TICKS); chk("R12 no restart while hot", -1, 1, 0, 4);
        ot_release = 1;
        idle(TICKS - 1); chk("R12 second period held", -1, 1, 0, 4);
        idle(1); chk("R12 restart after release", -1, 0, 1, 4);
        ot_release = 0;
        idle(1); chk("R12 cleared", -1, 0, 0, 0);

        // R9 priority
        ot_release = 1;
        cyc_in(1, 0, 0, 0, 1, 0, 0, 1); chk("R9 hot over ovolt", -1, 1, 0, 4);
        hold_restart("R9a", 4);
        ot_release = 0;
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 0, 0, 0, 0);
        cyc_in(1, 0, 0, 1, 1, 0, 0, 0); chk("R9 ovolt over short", -1, 1, 0, 1);
        hold_restart("R9b", 1);
        seq_phase = 2'd2;
        cyc_in(1, 0, 0, 0, 0, 0, 0, 0);
        cyc_in(1, 0, 0, 0, 1, 0, 0, 0); chk("R9 ovolt over sense", -1, 1, 0, 1);
        hold_restart("R9c", 1);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule